// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter that a host drives over a three-wire serial link: active-low chip select, serial clock and serial data-in. It samples the serial clock with its own system clock and finds the rising and falling edges of the serial clock. It runs an optional address phase that picks the input channel and the single-ended or differential pairing. It then ends the track window, drives a trial code to an external DAC and comparator, and reads back one comparator decision per step.

Each decision appears on serial data-out on the falling edge where it is resolved, so the result streams MSB-first while the approximation runs. After that the same code is shifted out again LSB-first. A status flag marks the approximation. A low-power flag is high whenever no acquisition or conversion is running. Raising chip select at any time aborts the frame. The parameter `NUM_CH` selects the variant: 1 gives a single fixed differential pair with no address phase, 2 gives the two-channel variant with the address phase.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `dout_oe_o`, `status_oe_o`, `status_o` and `hold_o` are 0, `trial_o` is 0 and `lowpower_o` is 1.
- R2: Inputs are sampled on serial-clock rising edges while `cs_ni` is low. In the two-channel variant, rising edges with `sdi_i`=0 are ignored until a start bit of 1 arrives. The next two rising edges capture the mode bit and then the select bit. In the one-channel variant, the first rising edge is the start.
- R3: In the two-channel variant, `sel_single_o` equals the captured mode bit (1 = single-ended) and `sel_odd_o` equals the captured select bit. Single-ended uses channel 1 when the select bit is 1 and channel 0 when it is 0. Differential uses (ch1 − ch0) when the select bit is 1 and (ch0 − ch1) when it is 0. In the one-channel variant, both outputs are 0.
- R4: `hold_o` stays 0 (tracking) through the address phase. On the falling edge that follows the last address rising edge, `hold_o` and `status_o` go to 1 and data-out is enabled, driving a null bit of 0.
- R5: On each of the next 8 falling edges, one bit is resolved, MSB first. `trial_o` is the bits already decided, OR'd with a 1 in the bit under test, and `trial_o` is 0 when no step is pending. A `comp_i` of 1 at the falling edge keeps that bit.
- R6: After each of those 8 falling edges, `dout_o` equals the decision just made.
- R7: `status_o` drops at the falling edge that resolves the LSB. `lowpower_o` is 0 exactly while tracking after the address phase or approximating.
- R8: The next 7 falling edges put result bits 1 through 7 on `dout_o`, bit 0 being shared with the end of the MSB-first stream. The falling edge after that drives `dout_o` to 0 until chip select rises.
- R9: While `cs_ni` is high, `dout_oe_o` and `status_oe_o` are 0. Raising `cs_ni` mid-frame returns the block to idle with `trial_o` 0 and `status_o` 0, and the next frame converts normally.
- R10: When the comparator never keeps a bit (negative input at or above the positive input), both streams carry code 0000_0000.
- R11: `status_oe_o` is 1 whenever `cs_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data-in (start and address bits) |
| comp_i | input | 1 | Comparator decision: analog held value >= trial code |
| dout_o | output | 1 | Serial data-out |
| dout_oe_o | output | 1 | Output enable for data-out pad |
| status_o | output | 1 | Approximation in progress |
| status_oe_o | output | 1 | Output enable for status pad |
| trial_o | output | RES_W | Trial code to the DAC |
| hold_o | output | 1 | 1 = hold the analog sample, 0 = track |
| sel_single_o | output | 1 | 1 = single-ended, 0 = differential |
| sel_odd_o | output | 1 | Channel or polarity select |
| lowpower_o | output | 1 | No acquisition or conversion running |

## Verification
The conversion is run over a table of mode and select settings with analog pairs. Single-ended codes on each channel tell apart a swapped or ignored select bit. Differential pairs in both polarities show whether the subtraction follows the select bit. Pairs with equal inputs or a negative input above the positive one must yield zero, which separates clamping from wrap-around. Directed frames add leading zero bits before the start bit, an abort in the middle of the approximation, and the null bit and first trial codes, which expose off-by-one errors in the edge counting.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACQ,
    ST_CONV,
    ST_SHIFT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/sar_addr_dec.sv
module sar_addr_dec #(
  parameter int NUM_CH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cap_i,
  input  logic sdi_i,
  output logic sel_single_o,
  output logic sel_odd_o,
  output logic addr_done_o
);
  if (NUM_CH > 1) begin : g_two_ch
    logic cnt_q, single_q, odd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q    <= 1'b0;
        single_q <= 1'b0;
        odd_q    <= 1'b0;
      end else if (clr_i) begin
        cnt_q    <= 1'b0;
        single_q <= 1'b0;
        odd_q    <= 1'b0;
      end else if (cap_i) begin
        if (!cnt_q) begin
          single_q <= sdi_i;
          cnt_q    <= 1'b1;
        end else begin
          odd_q    <= sdi_i;
        end
      end
    end

    assign sel_single_o = single_q;
    assign sel_odd_o    = odd_q;
    assign addr_done_o  = cap_i & cnt_q;
  end else begin : g_one_ch
    // fixed differential pair, no address phase
    assign sel_single_o = 1'b0;
    assign sel_odd_o    = 1'b0;
    assign addr_done_o  = cap_i;
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             shift_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             ser_o,
  output logic             last_step_o,
  output logic             last_shift_o
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] res_q;
  logic [IDX_W-1:0] step_q, sh_idx_q;
  logic             busy_q, ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q    <= '0;
      step_q   <= '0;
      sh_idx_q <= '0;
      busy_q   <= 1'b0;
      ser_q    <= 1'b0;
    end else if (clr_i) begin
      res_q    <= '0;
      step_q   <= '0;
      sh_idx_q <= '0;
      busy_q   <= 1'b0;
      ser_q    <= 1'b0;
    end else if (start_i) begin
      res_q    <= '0;
      step_q   <= IDX_TOP;
      busy_q   <= 1'b1;
      ser_q    <= 1'b0;  // null bit
    end else if (step_i && busy_q) begin
      res_q[step_q] <= comp_i;
      ser_q         <= comp_i;
      if (step_q == '0) begin
        busy_q   <= 1'b0;
        sh_idx_q <= IDX_W'(1);
      end else begin
        step_q <= step_q - 1'b1;
      end
    end else if (shift_i) begin
      ser_q <= res_q[sh_idx_q];
      if (sh_idx_q != IDX_TOP) sh_idx_q <= sh_idx_q + 1'b1;
    end
  end

  assign trial_o      = busy_q ? (res_q | (RES_W'(1) << step_q)) : '0;
  assign ser_o        = ser_q;
  assign last_step_o  = busy_q && (step_q == '0);
  assign last_shift_o = (sh_idx_q == IDX_TOP);

  assert_start_msb_trial_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> (trial_o == MSB_ONE));

  assert_ser_follows_comp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_q && !clr_i && !start_i) |=> (ser_o == $past(comp_i)));

  assert_kept_bit_stays_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && comp_i && busy_q && !last_step_o && !clr_i && !start_i)
      |=> ((trial_o & $past(trial_o)) == $past(trial_o)));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             comp_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             status_o,
  output logic             status_oe_o,
  output logic [RES_W-1:0] trial_o,
  output logic             hold_o,
  output logic             sel_single_o,
  output logic             sel_odd_o,
  output logic             lowpower_o
);
  localparam bit HAS_ADDR = (NUM_CH > 1);

  seq_state_e state_q, state_d;
  logic rise, fall;
  logic addr_done, last_step, last_shift, ser;
  logic clr, start, step, shift, cap;

  sar_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  sar_addr_dec #(.NUM_CH(NUM_CH)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (cs_ni),
    .cap_i        (cap),
    .sdi_i        (sdi_i),
    .sel_single_o (sel_single_o),
    .sel_odd_o    (sel_odd_o),
    .addr_done_o  (addr_done)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .start_i      (start),
    .step_i       (step),
    .shift_i      (shift),
    .comp_i       (comp_i),
    .trial_o      (trial_o),
    .ser_o        (ser),
    .last_step_o  (last_step),
    .last_shift_o (last_shift)
  );

  assign cap = !cs_ni && rise && (state_q == ST_ADDR);

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    start   = 1'b0;
    step    = 1'b0;
    shift   = 1'b0;
    if (cs_ni) begin
      state_d = ST_IDLE;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise) begin
          if (!HAS_ADDR)  state_d = ST_ACQ;
          else if (sdi_i) state_d = ST_ADDR;
        end
        ST_ADDR:  if (addr_done) state_d = ST_ACQ;
        ST_ACQ:   if (fall) begin
          start   = 1'b1;
          state_d = ST_CONV;
        end
        ST_CONV:  if (fall) begin
          step = 1'b1;
          if (last_step) state_d = ST_SHIFT;
        end
        ST_SHIFT: if (fall) begin
          shift = 1'b1;
          if (last_shift) state_d = ST_DONE;
        end
        ST_DONE:  if (fall) clr = 1'b1;  // trailing zeros
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  logic past_addr;
  assign past_addr   = (state_q == ST_CONV) || (state_q == ST_SHIFT) || (state_q == ST_DONE);
  assign dout_oe_o   = !cs_ni && past_addr;
  assign dout_o      = ser;
  assign hold_o      = past_addr;
  assign status_o    = (state_q == ST_CONV);
  assign status_oe_o = !cs_ni;
  assign lowpower_o  = !((state_q == ST_ACQ) || (state_q == ST_CONV));

  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (trial_o == '0 && !status_o && lowpower_o && !hold_o));

  assert_status_awake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> !lowpower_o);

  assert_hold_in_conv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trial_o != '0) |-> (hold_o && status_o));
endmodule

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb_top;
  localparam int RES_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, comp;
  logic dout, dout_oe, status, status_oe, hold, sel_single, sel_odd, lowpower;
  logic [RES_W-1:0] trial;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sar_seq_top #(.RES_W(RES_W), .NUM_CH(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .comp_i(comp), .dout_o(dout), .dout_oe_o(dout_oe), .status_o(status),
    .status_oe_o(status_oe), .trial_o(trial), .hold_o(hold),
    .sel_single_o(sel_single), .sel_odd_o(sel_odd), .lowpower_o(lowpower)
  );

  // analog front end model
  logic [7:0] ana0 = 8'h00, ana1 = 8'h00, held = 8'h00;
  logic hold_q = 1'b0;

  function automatic logic [7:0] expect_code(input logic sgl, input logic odd,
                                             input logic [7:0] a0, input logic [7:0] a1);
    logic [7:0] p, n;
    if (sgl) return odd ? a1 : a0;
    p = odd ? a1 : a0;
    n = odd ? a0 : a1;
    return (p > n) ? (p - n) : 8'h00;
  endfunction

  always @(posedge clk) begin
    hold_q <= hold;
    if (hold && !hold_q) held <= expect_code(sel_single, sel_odd, ana0, ana1);
  end
  assign comp = (held >= trial);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic v);
    sdi = v;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // captured frame observations
  logic [7:0] f_msb, f_lsb, f_trial0, f_trial1;
  logic f_lead_hold, f_lead_oe, f_acq_oe, f_acq_dout, f_acq_status, f_acq_hold;
  logic f_acq_soe, f_acq_lp, f_end_status, f_end_lp, f_tail;
  logic [1:0] f_sel;

  task automatic run_frame(input logic sgl, input logic odd, input int lead);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    f_lead_hold = hold;
    f_lead_oe   = dout_oe;
    pulse(1'b1);
    pulse(sgl);
    pulse(odd);
    f_acq_oe = dout_oe; f_acq_dout = dout; f_acq_status = status; f_acq_hold = hold;
    f_acq_soe = status_oe; f_acq_lp = lowpower; f_trial0 = trial;
    f_sel = {sel_single, sel_odd};
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0);
      f_msb[7-i] = dout;
      if (i == 0) f_trial1 = trial;
    end
    f_end_status = status;
    f_end_lp     = lowpower;
    f_lsb[0] = f_msb[0];
    for (int i = 1; i < 8; i++) begin
      pulse(1'b0);
      f_lsb[i] = dout;
    end
    pulse(1'b0);
    f_tail = dout;
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic       sgl;
    logic       odd;
    logic [7:0] a0;
    logic [7:0] a1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hA5, 8'h3C},
    '{1'b1, 1'b1, 8'hA5, 8'h3C},
    '{0, 0, 8'hC8, 8'h40},
    '{0, 1, 8'h40, 8'hC8},
    '{0, 0, 8'h40, 8'hC8},
    '{0, 0, 8'h7F, 8'h7F},
    '{1, 0, 8'hFF, 8'h00},
    '{1, 1, 8'h00, 8'h01}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 status_oe", status_oe, 0);
    chk("R1 status", status, 0);
    chk("R1 hold", hold, 0);
    chk("R1 trial", trial, 0);
    chk("R1 lowpower", lowpower, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] e;
      ana0 = VECS[v].a0;
      ana1 = VECS[v].a1;
      e = expect_code(VECS[v].sgl, VECS[v].odd, VECS[v].a0, VECS[v].a1);
      run_frame(VECS[v].sgl, VECS[v].odd, 0);
      chk("R5/R6 msb-first code", f_msb, e);
      chk("R8 lsb-first code", f_lsb, e);
      chk("R3 mux select", f_sel, {VECS[v].sgl, VECS[v].odd});
      if (e == 8'h00) chk("R10 zero code when neg>=pos", f_msb | f_lsb, 0);
    end

    // directed: acquisition, null bit, trial codes, status timing
    ana0 = 8'hC3; ana1 = 8'h00;
    run_frame(1'b1, 1'b0, 0);
    chk("R4 dout enabled after acquisition", f_acq_oe, 1);
    chk("R4 null bit", f_acq_dout, 0);
    chk("R4 status high", f_acq_status, 1);
    chk("R4 hold high", f_acq_hold, 1);
    chk("R11 status_oe with cs low", f_acq_soe, 1);
    chk("R7 lowpower low while converting", f_acq_lp, 0);
    chk("R5 first trial", f_trial0, 8'h80);
    chk("R5 second trial after kept bit", f_trial1, 8'hC0);
    chk("R7 status low after lsb", f_end_status, 0);
    chk("R7 lowpower after lsb", f_end_lp, 1);
    chk("R8 trailing zero", f_tail, 0);
    chk("R6 code", f_msb, 8'hC3);

    // R2 leading zeros before start bit
    ana0 = 8'h5A;
    run_frame(1'b1, 1'b0, 2);
    chk("R2 no hold during leading zeros", f_lead_hold, 0);
    chk("R2 no dout during leading zeros", f_lead_oe, 0);
    chk("R2 code after leading zeros", f_msb, 8'h5A);

    // R9 abort mid-conversion
    ana0 = 8'h00; ana1 = 8'h9E;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    chk("R9 busy before abort", status, 1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 dout_oe after abort", dout_oe, 0);
    chk("R9 status_oe after abort", status_oe, 0);
    chk("R9 status after abort", status, 0);
    chk("R9 trial after abort", trial, 0);
    chk("R9 lowpower after abort", lowpower, 1);
    run_frame(1'b1, 1'b1, 0);
    chk("R9 frame after abort", f_msb, 8'h9E);
    chk("R9 lsb after abort", f_lsb, 8'h9E);

    finish_run();
  end
endmodule